// File: doc/BRIEF.md
# Microcontroller Mailbox Register Interface

This block sits between a processor register bus and a byte-wide link to a housekeeping microcontroller. The host writes command bytes into a 16-entry transmit FIFO and reads reply bytes from a 16-entry receive FIFO, both through a single data register. The link side drains the transmit FIFO with a valid/ready handshake and delivers received bytes with a valid strobe.

FIFO conditions are kept as sticky status bits that software clears by writing 1. A bit whose condition is a level (transmit empty, transmit not full, receive not empty) comes back one cycle after being cleared if the condition still holds. Receive overflow is an event: it is set when a byte arrives at a full receive FIFO and stays set until cleared. An interrupt register carries four enable bits next to four read-only request bits, and a single interrupt line is raised whenever an enabled status bit is set.

Top module: `mcu_mailbox`

## Requirements
- R1: After reset both FIFOs are empty, status reads 0x03 (transmit empty and transmit not full set), all enables are 0, `irq` is low and `tx_valid` is low.
- R2: Registers are selected by `bus_addr`: 0x0 interrupt, 0x4 data, 0x8 status; any other address, including unaligned ones, reads 0x00 and ignores writes. Reads are combinational and valid in the cycle `bus_sel` is high.
- R3: Status bit 0 is transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive overflow, bits 7:4 read 0. A status write clears every bit written as 1 at that clock edge; bits written as 0 are unchanged.
- R4: A cleared level status bit (bits 2:0) is set again at the next clock edge if its condition still holds, and stays 0 while it does not.
- R5: In the interrupt register, bits 7:4 are read/write enables for status bits 3:0 (bit 4 enables status bit 0, and so on); bits 3:0 read as status AND enable, and writes to bits 3:0 are ignored.
- R6: `irq` is high exactly when some status bit and its enable are both 1.
- R7: A data write pushes `bus_wdata` into the transmit FIFO; a write to a full FIFO is dropped. `tx_valid` is high while the FIFO holds a byte, `tx_data` shows the oldest byte, and a byte is removed on a cycle with `tx_valid` and `tx_ready` both high, in write order.
- R8: A data read returns the oldest receive byte and removes it at that clock edge; a data read of an empty receive FIFO returns 0x00 and removes nothing.
- R9: A byte arriving with `rx_valid` while the receive FIFO is full is dropped and sets status bit 3 at that edge; bit 3 stays set until cleared and is not set again by a clear alone.
- R10: Each FIFO holds exactly 16 bytes; the 16th byte is accepted and the 17th is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Link accepts the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |

## Verification
Read data is due in the same cycle as the access, so the bench drives each access after a falling edge and samples `bus_rdata` before the next rising edge. Every state change — FIFO push and pop, status set and clear, the overflow event, the enable write and hence `irq` — is due at the first rising edge after the stimulus, and the bench samples those one time step after that edge. The only two-edge result is the return of a cleared level bit, which the bench checks by reading status twice in a row: 0 on the first read and 1 on the second, or 0 on both when the condition is gone.

// File: rtl/mcu_mailbox.sv
module mcu_mailbox #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_cnt_n, rx_cnt_n;
  logic [3:0]    sta, sta_n, mask, cond, clr;

  wire hit     = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  wire sel_int = bus_sel && hit && (bus_addr[3:2] == 2'd0);
  wire sel_dat = bus_sel && hit && (bus_addr[3:2] == 2'd1);
  wire sel_sta = bus_sel && hit && (bus_addr[3:2] == 2'd2);

  wire tx_push = sel_dat && bus_wr && (tx_cnt != FULL);
  wire tx_pop  = tx_valid && tx_ready;
  wire rx_push = rx_valid && (rx_cnt != FULL);
  wire rx_pop  = sel_dat && !bus_wr && (rx_cnt != '0);
  wire rx_ovf  = rx_valid && (rx_cnt == FULL);

  assign tx_cnt_n = tx_cnt + CW'(tx_push) - CW'(tx_pop);
  assign rx_cnt_n = rx_cnt + CW'(rx_push) - CW'(rx_pop);

  assign tx_valid = (tx_cnt != '0);
  assign tx_data  = tx_mem[tx_rp];

  assign cond  = {rx_ovf, rx_cnt_n != '0, tx_cnt_n != FULL, tx_cnt_n == '0};
  assign clr   = (sel_sta && bus_wr) ? bus_wdata[3:0] : 4'b0000;
  assign sta_n = (clr & {rx_ovf, 3'b000}) | (~clr & (sta | cond));
  assign irq   = |(sta & mask);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      tx_cnt <= '0;
      rx_cnt <= '0;
      sta    <= 4'b0011;
      mask   <= 4'b0000;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt_n;
      rx_cnt <= rx_cnt_n;
      sta    <= sta_n;
      if (sel_int && bus_wr) mask <= bus_wdata[7:4];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (sel_int) bus_rdata = {mask, sta & mask};
    if (sel_dat) bus_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : 8'h00;
    if (sel_sta) bus_rdata = {4'h0, sta};
  end

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 4'b0000));

  // R9
  overflow_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_cnt == FULL) |=> sta[3]);

  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(8) && bus_wdata[1]) |=> !sta[1]);

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= FULL) && (tx_cnt <= FULL));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(4) && rx_cnt == '0 && !rx_valid) |=> (rx_cnt == '0));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(bus_sel && bus_wr)) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/mcu_mailbox_test.sv
module mcu_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] tx_data, rx_data = 8'h00;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mcu_mailbox uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [7:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  // op: 0 write, 1 read-and-compare, 2 receive byte; fields {req, op, addr, data, exp, irq}
  localparam int NV = 17;
  localparam logic [26:0] VEC [NV] = '{
    {4'd1, 2'd1, 4'h8, 8'h00, 8'h03, 1'b0},  // R1 status after reset
    {4'd5, 2'd0, 4'h0, 8'h40, 8'h00, 1'b0},  // R5 enable rx not empty
    {4'd6, 2'd2, 4'h0, 8'hA5, 8'h00, 1'b1},  // R6 byte arrives, irq
    {4'd3, 2'd1, 4'h8, 8'h00, 8'h07, 1'b1},  // R3 status shows rx not empty
    {4'd5, 2'd1, 4'h0, 8'h00, 8'h44, 1'b1},  // R5 request = status & enable
    {4'd8, 2'd1, 4'h4, 8'h00, 8'hA5, 1'b1},  // R8 pop, sticky bit keeps irq
    {4'd3, 2'd0, 4'h8, 8'h04, 8'h00, 1'b0},  // R3 clear rx not empty
    {4'd4, 2'd1, 4'h8, 8'h00, 8'h03, 1'b0},  // R4 stays clear when empty
    {4'd7, 2'd0, 4'h4, 8'h3C, 8'h00, 1'b0},  // R7 transmit push
    {4'd3, 2'd0, 4'h8, 8'h01, 8'h00, 1'b0},  // R3 clear tx empty
    {4'd3, 2'd1, 4'h8, 8'h00, 8'h02, 1'b0},  // R3 tx empty gone
    {4'd3, 2'd0, 4'h8, 8'h02, 8'h00, 1'b0},  // R3 clear tx not full
    {4'd4, 2'd1, 4'h8, 8'h00, 8'h00, 1'b0},  // R4 cleared this edge
    {4'd4, 2'd1, 4'h8, 8'h00, 8'h02, 1'b0},  // R4 back one edge later
    {4'd5, 2'd0, 4'h0, 8'h2F, 8'h00, 1'b1},  // R5 request bits ignored
    {4'd5, 2'd1, 4'h0, 8'h00, 8'h22, 1'b1},  // R5 readback
    {4'd6, 2'd0, 4'h0, 8'h00, 8'h00, 1'b0}   // R6 no enable, no irq
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", {6'd0, irq, tx_valid}, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[26:23], i);
      @(negedge clk);
      case (v[22:21])
        2'd0: begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = v[20:17]; bus_wdata = v[16:9]; end
        2'd1: begin bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = v[20:17]; end
        default: begin rx_valid = 1'b1; rx_data = v[16:9]; end
      endcase
      #1;
      if (v[22:21] == 2'd1) chk(tag, bus_rdata, v[8:1]);
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
      chk({tag, " irq"}, {7'd0, irq}, {7'd0, v[0]});
    end

    // R1: reset empties both FIFOs
    push(8'h11);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 irq/tx_valid in reset", {6'd0, irq, tx_valid}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    rd("R1 status", 4'h8, 8'h03);
    rd("R1 enables", 4'h0, 8'h00);
    rd("R1 rx empty", 4'h4, 8'h00);
    chk("R1 tx empty", {7'd0, tx_valid}, 8'h00);

    // R2: unmapped and unaligned addresses
    wr(4'h5, 8'hF0);
    rd("R2 unaligned write ignored", 4'h0, 8'h00);
    rd("R2 unmapped read", 4'hC, 8'h00);
    rd("R2 unaligned read", 4'h9, 8'h00);
    wr(4'h8, 8'h00);
    rd("R3 zero write no effect", 4'h8, 8'h03);

    // R9/R10: receive fill and overflow
    wr(4'h0, 8'h80);
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 1));
    rd("R10 16 bytes no overflow", 4'h8, 8'h07);
    chk("R6 no irq before overflow", {7'd0, irq}, 8'h00);
    push(8'hEE);
    chk("R9 irq on overflow", {7'd0, irq}, 8'h01);
    rd("R9 overflow status", 4'h8, 8'h0F);
    rd("R5 request readback", 4'h0, 8'h88);
    for (int i = 0; i < 16; i++) rd("R8 receive order", 4'h4, 8'(i * 7 + 1));
    rd("R10 17th dropped", 4'h4, 8'h00);
    rd("R9 overflow sticky", 4'h8, 8'h0F);
    wr(4'h8, 8'h0C);
    rd("R9 overflow cleared", 4'h8, 8'h03);
    rd("R9 overflow not re-set", 4'h8, 8'h03);
    chk("R6 irq dropped", {7'd0, irq}, 8'h00);

    // R7/R10: transmit fill, drop, drain
    for (int i = 0; i < 16; i++) wr(4'h4, 8'(8'hA0 + i));
    chk("R7 tx_valid", {7'd0, tx_valid}, 8'h01);
    chk("R7 tx head", tx_data, 8'hA0);
    wr(4'h8, 8'h02);
    rd("R4 full: not-full cleared", 4'h8, 8'h01);
    rd("R4 full: not-full stays 0", 4'h8, 8'h01);
    wr(4'h4, 8'h55);
    @(negedge clk) tx_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      #1 chk("R7 drain order", tx_data, 8'(8'hA0 + i));
      @(negedge clk);
    end
    chk("R10 tx 17th dropped", {7'd0, tx_valid}, 8'h00);
    tx_ready = 1'b0;
    rd("R4 not-full returns", 4'h8, 8'h03);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule